// File: doc/BRIEF.md
# Rotate and Mask Unit

A combinational rotate-then-mask datapath for a 64-bit integer pipeline. It rotates a source operand left, builds a contiguous (or wrapped) bit mask and either clears every bit outside the mask or fills those bits from a second operand. The raw instruction fields arrive unchanged: a rotate amount, a mask-begin field, a mask-end field, a three-bit operation select and a word flag. Decode beyond these fields is done elsewhere.

Mask positions use most-significant-first numbering: position 0 is the top bit of the value and position XLEN-1 is the bottom bit. A mask covers positions begin through end inclusive. When begin is past end, the mask wraps around both ends of the word. Two mask generator structures are available through a parameter.

The operation select is encoded as `{insert, kind[1:0]}`. The kind values are: 0 mask from both fields, 1 clear-both (end derived from the amount), 2 clear-left, 3 clear-right. In word mode the kind is ignored and the mask always comes from both fields. The carry output is always low.

Top module: `rotmask_unit`

## Requirements
- R1: When the mask begin position is not greater than the end position, exactly the positions begin..end are set, with position p being value bit XLEN-1-p.
- R2: When begin is greater than end, the mask wraps: positions begin..XLEN-1 and 0..end are set, and only those.
- R3: With word_i high, the low half of src_i is copied into both halves, the rotate amount uses only its low SHW-1 bits (the top amount bit has no effect), and both mask fields use their low SHW-1 bits with XLEN/2 added.
- R4: The result is (rotated AND mask) OR (ins_i AND NOT mask) when op_sel_i[2] is 1. When op_sel_i[2] is 0, ins_i has no effect and bits outside the mask are 0.
- R5: In doubleword mode the rotate uses all SHW amount bits, and a mask field f is decoded as {f[0], f[SHW-1:1]}, so that field bit 0 is the most significant bit of the position.
- R6: Doubleword kind 1 (clear-both / insert) uses the decoded begin field as start and XLEN-1 minus the amount as end.
- R7: Doubleword kind 2 (clear-left) uses the decoded begin field as start and XLEN-1 as end.
- R8: Doubleword kind 3 (clear-right) uses 0 as start and the decoded end field as end. Doubleword kind 0 uses the decoded begin and decoded end fields.
- R9: carry_o is 0 for every input.
- R10: In word mode, op_sel_i[1:0] has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | XLEN | Operand to rotate |
| ins_i | input | XLEN | Operand whose bits fill positions outside the mask when inserting |
| amt_i | input | SHW | Rotate-left amount (register or immediate, chosen upstream) |
| mb_i | input | SHW | Raw mask-begin field |
| me_i | input | SHW | Raw mask-end field |
| op_sel_i | input | 3 | {insert, kind[1:0]} |
| word_i | input | 1 | 1 = word operation, 0 = doubleword |
| res_o | output | XLEN | Result |
| carry_o | output | 1 | Carry out, always 0 |

## Verification
The bench builds two copies at XLEN=64: one with the per-position comparator mask generator (MASK_STYLE=0) and one with the shift-and-XOR generator (MASK_STYLE=1). Both are checked against a loop-based model on every clock. At 64 bits, every field-decode path and the wrap case of the mask are reachable. This width also covers the full-width extremes: begin 0 with end 63, begin equal to end plus one (all ones), and amounts with the top bit set in word mode. Random operands then spread the checks across all select codes, both modes and both wrap conditions.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

   // Low two bits of the operation select
   typedef enum logic [1:0] {
      KIND_FIELDS = 2'd0,
      KIND_BOTH   = 2'd1,
      KIND_LEFT   = 2'd2,
      KIND_RIGHT  = 2'd3
   } rm_kind_e;

   localparam int OPSEL_W   = 3;
   localparam int OPSEL_INS = 2;

endpackage

// File: rtl/rotmask_rotl.sv
// Logarithmic left rotator: one stage per amount bit
module rotmask_rotl #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]         data_i,
   input  logic [$clog2(XLEN)-1:0] amt_i,
   output logic [XLEN-1:0]         data_o
);
   localparam int SHW = $clog2(XLEN);

   logic [XLEN-1:0] stage [SHW+1];

   assign stage[0] = data_i;

   for (genvar k = 0; k < SHW; k++) begin : g_stage
      localparam int STEP = 1 << k;
      assign stage[k+1] = amt_i[k]
         ? {stage[k][XLEN-1-STEP:0], stage[k][XLEN-1:XLEN-STEP]}
         : stage[k];
   end

   assign data_o = stage[SHW];

endmodule

// File: rtl/rotmask_maskgen.sv
// Mask generator, MSB-first positions, wraps when start > stop
module rotmask_maskgen #(
   parameter int XLEN       = 64,
   parameter int MASK_STYLE = 0
) (
   input  logic [$clog2(XLEN)-1:0] start_i,
   input  logic [$clog2(XLEN)-1:0] stop_i,
   output logic [XLEN-1:0]         mask_o
);
   localparam int SHW = $clog2(XLEN);

   logic wrap;
   assign wrap = start_i > stop_i;

   if (MASK_STYLE == 0) begin : g_cmp
      // One comparator pair per position
      for (genvar p = 0; p < XLEN; p++) begin : g_pos
         localparam logic [SHW-1:0] POS = SHW'(p);
         logic ge_start;
         logic le_stop;
         assign ge_start = POS >= start_i;
         assign le_stop  = POS <= stop_i;
         assign mask_o[XLEN-1-p] = wrap ? (ge_start | le_stop)
                                        : (ge_start & le_stop);
      end
   end else begin : g_shift
      // Two right shifts of all-ones, XORed: gives the run between the bounds
      localparam logic [XLEN-1:0] ONES = '1;
      logic [XLEN-1:0] from_start;
      logic [XLEN-1:0] past_stop;
      logic [XLEN-1:0] run;
      assign from_start = ONES >> start_i;
      assign past_stop  = (ONES >> stop_i) >> 1;
      assign run        = from_start ^ past_stop;
      assign mask_o     = wrap ? ~run : run;
   end

endmodule

// File: rtl/rotmask_ctrl.sv
// Field decode: rotate source, amount and mask bounds per mode
module rotmask_ctrl
   import rotmask_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]         src_i,
   input  logic [$clog2(XLEN)-1:0] amt_i,
   input  logic [$clog2(XLEN)-1:0] mb_i,
   input  logic [$clog2(XLEN)-1:0] me_i,
   input  logic [OPSEL_W-1:0]      op_sel_i,
   input  logic                    word_i,
   output logic [XLEN-1:0]         rot_src_o,
   output logic [$clog2(XLEN)-1:0] rot_amt_o,
   output logic [$clog2(XLEN)-1:0] mstart_o,
   output logic [$clog2(XLEN)-1:0] mstop_o,
   output logic                    ins_en_o
);
   localparam int SHW  = $clog2(XLEN);
   localparam int HALF = XLEN / 2;

   // Field bit 0 carries the position's most significant bit
   function automatic logic [SHW-1:0] decode_field(input logic [SHW-1:0] f);
      return {f[0], f[SHW-1:1]};
   endfunction

   rm_kind_e         kind;
   logic [SHW-1:0]   mb_dec;
   logic [SHW-1:0]   me_dec;

   assign kind     = rm_kind_e'(op_sel_i[1:0]);
   assign mb_dec   = decode_field(mb_i);
   assign me_dec   = decode_field(me_i);
   assign ins_en_o = op_sel_i[OPSEL_INS];

   always_comb begin
      if (word_i) begin
         rot_src_o = {src_i[HALF-1:0], src_i[HALF-1:0]};
         rot_amt_o = {1'b0, amt_i[SHW-2:0]};
         // adding HALF to a value below HALF sets the top bit
         mstart_o  = {1'b1, mb_i[SHW-2:0]};
         mstop_o   = {1'b1, me_i[SHW-2:0]};
      end else begin
         rot_src_o = src_i;
         rot_amt_o = amt_i;
         unique case (kind)
            KIND_FIELDS: begin
               mstart_o = mb_dec;
               mstop_o  = me_dec;
            end
            KIND_BOTH: begin
               mstart_o = mb_dec;
               mstop_o  = ~amt_i;          // XLEN-1 minus amount
            end
            KIND_LEFT: begin
               mstart_o = mb_dec;
               mstop_o  = '1;
            end
            default: begin
               mstart_o = '0;
               mstop_o  = me_dec;
            end
         endcase
      end
   end

endmodule

// File: rtl/rotmask_unit.sv
// Rotate and mask unit, top level
module rotmask_unit
   import rotmask_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int MASK_STYLE = 0,
   localparam int SHW       = $clog2(XLEN)
) (
   input  logic [XLEN-1:0]    src_i,
   input  logic [XLEN-1:0]    ins_i,
   input  logic [SHW-1:0]     amt_i,
   input  logic [SHW-1:0]     mb_i,
   input  logic [SHW-1:0]     me_i,
   input  logic [OPSEL_W-1:0] op_sel_i,
   input  logic               word_i,
   output logic [XLEN-1:0]    res_o,
   output logic               carry_o
);
   if (XLEN < 8 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
      $error("rotmask_unit: XLEN must be a power of two of at least 8");
   end
   if (MASK_STYLE != 0 && MASK_STYLE != 1) begin : g_bad_style
      $error("rotmask_unit: MASK_STYLE must be 0 or 1");
   end

   logic [XLEN-1:0] rot_src_w;
   logic [SHW-1:0]  rot_amt_w;
   logic [SHW-1:0]  mstart_w;
   logic [SHW-1:0]  mstop_w;
   logic            ins_en_w;
   logic [XLEN-1:0] rot_w;
   logic [XLEN-1:0] mask_w;
   logic [XLEN-1:0] fill_w;

   rotmask_ctrl #(.XLEN(XLEN)) u_ctrl (
      .src_i    (src_i),
      .amt_i    (amt_i),
      .mb_i     (mb_i),
      .me_i     (me_i),
      .op_sel_i (op_sel_i),
      .word_i   (word_i),
      .rot_src_o(rot_src_w),
      .rot_amt_o(rot_amt_w),
      .mstart_o (mstart_w),
      .mstop_o  (mstop_w),
      .ins_en_o (ins_en_w)
   );

   rotmask_rotl #(.XLEN(XLEN)) u_rotl (
      .data_i(rot_src_w),
      .amt_i (rot_amt_w),
      .data_o(rot_w)
   );

   rotmask_maskgen #(.XLEN(XLEN), .MASK_STYLE(MASK_STYLE)) u_mask (
      .start_i(mstart_w),
      .stop_i (mstop_w),
      .mask_o (mask_w)
   );

   assign fill_w  = ins_en_w ? ins_i : '0;
   assign res_o   = (rot_w & mask_w) | (fill_w & ~mask_w);
   assign carry_o = 1'b0;

endmodule

// File: rtl/rotmask_unit_chk.sv
// Property checker bound into every rotmask_unit
module rotmask_unit_chk #(
   parameter int XLEN = 64,
   localparam int SHW = $clog2(XLEN)
) (
   input logic [XLEN-1:0] ins_i,
   input logic [SHW-1:0]  mb_i,
   input logic [SHW-1:0]  me_i,
   input logic [2:0]      op_sel_i,
   input logic            word_i,
   input logic [XLEN-1:0] res_o,
   input logic [XLEN-1:0] rot_w,
   input logic [XLEN-1:0] mask_w,
   input logic [SHW-1:0]  mstart_w,
   input logic [SHW-1:0]  mstop_w
);
   localparam int HALF = XLEN / 2;

   always_comb begin
      if (mstart_w <= mstop_w) begin
         assert_run_count_R1: assert ($countones(mask_w) ==
                                      int'(mstop_w) - int'(mstart_w) + 1)
            else $error("mask population wrong for plain run");
         assert_run_edge_R1: assert (mask_w[XLEN-1-int'(mstart_w)] &&
                                     mask_w[XLEN-1-int'(mstop_w)])
            else $error("mask bounds not set");
      end else begin
         assert_wrap_count_R2: assert ($countones(mask_w) ==
                                       XLEN - (int'(mstart_w) - int'(mstop_w)) + 1)
            else $error("mask population wrong for wrapped run");
      end

      assert_inside_R4: assert ((res_o & mask_w) == (rot_w & mask_w))
         else $error("masked bits differ from rotated value");
      if (!op_sel_i[2]) begin
         assert_clear_R4: assert ((res_o & ~mask_w) == '0)
            else $error("bits outside mask not cleared");
      end else begin
         assert_fill_R4: assert ((res_o & ~mask_w) == (ins_i & ~mask_w))
            else $error("bits outside mask not taken from insert operand");
      end

      if (!word_i && op_sel_i[1:0] == 2'd2) begin
         assert_left_end_R7: assert (mask_w[0])
            else $error("clear-left mask must reach the last position");
      end
      if (!word_i && op_sel_i[1:0] == 2'd3) begin
         assert_right_start_R8: assert (mask_w[XLEN-1])
            else $error("clear-right mask must start at position 0");
      end

      if (word_i && mb_i[SHW-2:0] <= me_i[SHW-2:0]) begin
         assert_word_upper_R3: assert (res_o[XLEN-1:HALF] ==
                                       (op_sel_i[2] ? ins_i[XLEN-1:HALF] : '0))
            else $error("word result upper half wrong");
      end
   end

endmodule

bind rotmask_unit rotmask_unit_chk #(.XLEN(XLEN)) u_rotmask_unit_chk (
   .ins_i   (ins_i),
   .mb_i    (mb_i),
   .me_i    (me_i),
   .op_sel_i(op_sel_i),
   .word_i  (word_i),
   .res_o   (res_o),
   .rot_w   (rot_w),
   .mask_w  (mask_w),
   .mstart_w(mstart_w),
   .mstop_w (mstop_w)
);

// File: tb/rotmask_unit_bench.sv
module rotmask_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN       = 64;
   localparam int SHW        = 6;
   localparam int WATCHDOG   = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [XLEN-1:0] src, ins;
   logic [SHW-1:0]  amt, mb, me;
   logic [2:0]      sel;
   logic            word;
   logic [XLEN-1:0] res_a, res_b;
   logic            cy_a, cy_b;

   rotmask_unit #(.XLEN(XLEN), .MASK_STYLE(0)) u_rotmask_unit (
      .src_i(src), .ins_i(ins), .amt_i(amt), .mb_i(mb), .me_i(me),
      .op_sel_i(sel), .word_i(word), .res_o(res_a), .carry_o(cy_a));

   rotmask_unit #(.XLEN(XLEN), .MASK_STYLE(1)) u_rotmask_unit_alt (
      .src_i(src), .ins_i(ins), .amt_i(amt), .mb_i(mb), .me_i(me),
      .op_sel_i(sel), .word_i(word), .res_o(res_b), .carry_o(cy_b));

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   // ---------------- behavioural model ----------------
   function automatic int dec(input int f);
      return (f % 2) * 32 + f / 2;
   endfunction

   function automatic int enc(input int v);   // position -> raw field
      return ((v % 32) * 2) + (v / 32);
   endfunction

   function automatic logic [63:0] model(
      input logic [63:0] s, input logic [63:0] fill, input int a,
      input int b_f, input int e_f, input int op, input bit w);
      logic [63:0] v, r, m;
      int sh, b, e;
      v = s;
      sh = a;
      if (w) begin
         v = {s[31:0], s[31:0]};
         sh = a % 32;
         b = (b_f % 32) + 32;
         e = (e_f % 32) + 32;
      end else begin
         case (op % 4)
            0: begin b = dec(b_f); e = dec(e_f); end
            1: begin b = dec(b_f); e = 63 - a; end
            2: begin b = dec(b_f); e = 63; end
            default: begin b = 0; e = dec(e_f); end
         endcase
      end
      r = '0;
      for (int i = 0; i < 64; i++) r[(i + sh) % 64] = v[i];
      m = '0;
      for (int p = 0; p < 64; p++) begin
         if (b <= e) m[63-p] = (p >= b) && (p <= e);
         else        m[63-p] = (p >= b) || (p <= e);
      end
      return (r & m) | ((op >= 4) ? (fill & ~m) : 64'd0);
   endfunction

   task automatic check(input string tag, input logic [63:0] got,
                        input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic apply(input logic [63:0] s, input logic [63:0] fill,
                        input int a, input int b_f, input int e_f,
                        input int op, input bit w);
      @(posedge clk);
      src = s; ins = fill; amt = SHW'(a); mb = SHW'(b_f); me = SHW'(e_f);
      sel = 3'(op); word = w;
      @(negedge clk);
   endtask

   task automatic full(input string tag, input logic [63:0] exp);
      logic [63:0] m;
      m = model(src, ins, int'(amt), int'(mb), int'(me), int'(sel), word);
      check({tag, " model"}, m, exp);
      check({tag, " style0"}, res_a, exp);
      check({tag, " style1"}, res_b, exp);
      check("R9 carry", {63'd0, cy_a | cy_b}, 64'd0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   initial begin
      src = '0; ins = '0; amt = '0; mb = '0; me = '0; sel = '0; word = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      full("reset idle R9", 64'd0);

      // R1: begin 0, end 63, ones in -> ones out
      apply('1, '0, 0, enc(0), enc(63), 0, 1'b0);
      full("R1 full run", '1);
      // R1: single position 5 -> bit 58
      apply('1, '0, 0, enc(5), enc(5), 0, 1'b0);
      full("R1 single bit", 64'h0400_0000_0000_0000);
      // R2: wrap 62..1
      apply('1, '0, 0, enc(62), enc(1), 0, 1'b0);
      full("R2 wrap", 64'hC000_0000_0000_0003);
      // R2: begin = end+1 -> all ones
      apply('1, '0, 0, enc(10), enc(9), 0, 1'b0);
      full("R2 wrap full", '1);
      // R3: word rotate by 4, mask positions 32..63
      apply(64'hFFFF_FFFF_1234_5678, '0, 4, 0, 31, 0, 1'b1);
      full("R3 word rot", 64'h0000_0000_2345_6781);
      // R3: top amount bit ignored in word mode
      apply(64'hFFFF_FFFF_1234_5678, '0, 36, 0, 31, 0, 1'b1);
      full("R3 amt top bit", 64'h0000_0000_2345_6781);
      // R3: word wrapped mask covers upper half
      apply(64'h0000_0000_8000_0001, '0, 0, 31, 0, 0, 1'b1);
      full("R3 word wrap", 64'h8000_0001_8000_0001);
      // R5 + R7: field 6'b000001 decodes to 32
      apply('1, '0, 0, 1, 0, 2, 1'b0);
      full("R5 R7 clear-left", 64'h0000_0000_FFFF_FFFF);
      // R6: clear-both amount 8, begin 0 -> end 55
      apply(64'd1, '0, 8, enc(0), 0, 1, 1'b0);
      full("R6 clear-both", 64'h0000_0000_0000_0100);
      apply('1, '0, 8, enc(0), 0, 1, 1'b0);
      full("R6 clear-both mask", 64'hFFFF_FFFF_FFFF_FF00);
      // R8: clear-right end field 7 -> positions 0..7
      apply('1, '0, 0, 0, enc(7), 3, 1'b0);
      full("R8 clear-right", 64'hFF00_0000_0000_0000);
      // R4: insert, clear-both with amount 0, begin 32
      apply('0, '1, 0, enc(32), 0, 5, 1'b0);
      full("R4 insert", 64'hFFFF_FFFF_0000_0000);
      // R4: insert bit clear -> ins ignored
      apply('0, '1, 0, enc(32), 0, 1, 1'b0);
      full("R4 no insert", 64'd0);
      // R10: word mode ignores kind
      apply(64'h0000_0000_1234_5678, '0, 8, 4, 27, 3, 1'b1);
      full("R10 word kind", model(64'h0000_0000_1234_5678, '0, 8, 4, 27, 0, 1'b1));
      check("R10 word kind vs literal", res_a, 64'h0000_0000_0456_7810);

      // Random sweep, all modes
      for (int n = 0; n < 3000; n++) begin
         logic [63:0] s, f, e;
         int a, bf, ef, op;
         bit w;
         s = {$urandom, $urandom};
         f = {$urandom, $urandom};
         a = $urandom % 64; bf = $urandom % 64; ef = $urandom % 64;
         op = $urandom % 8; w = 1'($urandom % 2);
         apply(s, f, a, bf, ef, op, w);
         e = model(s, f, a, bf, ef, op, w);
         check("R1 R2 R4 random style0", res_a, e);
         check("R5 R6 R7 R8 random style1", res_b, e);
         check("R9 carry random", {63'd0, cy_a | cy_b}, 64'd0);
      end

      finish_run();
   end

endmodule